// File: doc/BRIEF.md
# I2C Target Address Recognizer with Don't-Care Mask

This block sits behind the bit-level receiver of an I2C target. For every address byte the receiver has assembled, it decides whether the target should acknowledge. It handles 7-bit and 10-bit addressing. A per-bit mask turns chosen bits of the programmed address into don't-cares. A fixed filter rejects the protocol's reserved addresses, and no mask setting can override it. The general-call address has its own enable and its own indication. In 10-bit mode, a full match needs two compares: the header byte, then the low byte. After a full match, a header arriving after a repeated START with the read bit set is accepted without a low byte.

The receiver gives the block three single-cycle strobes: a START seen, a STOP seen, and a byte assembled. The byte strobe carries the byte on `byte_data`. Bits [7:1] hold the address bits and bit 0 holds the direction bit (1 = read). The block has no ready signal. It takes every strobe, so the receiver never has to hold a byte back. The verdict is registered and appears on the clock after the strobe. It stays there until the next address byte, START or STOP. When START and STOP strobe in the same cycle, STOP wins. A byte strobe in the same cycle as START or STOP is dropped.

Top module: `i2c_addr_match`

## Requirements
- R1: After reset, `byte_ack`, `addr_match`, `gen_call` and `read_dir` are all 0.
- R2: In 7-bit mode, the first byte after START is accepted when each address bit either equals the matching bit of `own_addr[6:0]` or has its `addr_mask` bit set to 1. Acceptance sets `byte_ack` and `addr_match` to 1 one clock after the strobe, and sets `read_dir` to byte bit 0. Any other byte sets all four outputs to 0.
- R3: While `mask_bypass` is 1, `addr_mask` is ignored and every compare is exact, in both modes.
- R4: A first byte whose 7-bit address has its upper four bits equal to 0000 or 1111 is never accepted as an own address, whatever the mask and own address are. In 7-bit mode this includes the 10-bit header pattern 11110xx.
- R5: The byte 0x00 (general call, write) gives `byte_ack`=1 and `gen_call`=1 with `addr_match`=0 when `gc_enable` is 1. It gives all 0 when `gc_enable` is 0. This holds in both modes and is never reached through the mask.
- R6: In 10-bit mode, a first byte with bits [7:3]=11110, bit 0=0 and bits [2:1] matching `own_addr[9:8]` under the mask gives `byte_ack`=1 and `addr_match`=0. No other first byte except general call is acknowledged, unless R8 applies.
- R7: After an accepted 10-bit header, the next byte is compared with `own_addr[7:0]` under the mask. On a match, `byte_ack`=1 and `addr_match`=1. Otherwise all outputs are 0.
- R8: After a full 10-bit match and a repeated START, an accepted header with bit 0=1 gives `byte_ack`, `addr_match` and `read_dir` all 1. Without a full match since the last STOP, the same header gives all 0.
- R9: A START or STOP strobe clears all four outputs on the next clock. A STOP also forgets any earlier full 10-bit match.
- R10: Once the address phase is decided, further byte strobes until the next START leave every output unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_evt | input | 1 | START or repeated START seen (one-cycle strobe) |
| stop_evt | input | 1 | STOP seen (one-cycle strobe) |
| byte_valid | input | 1 | Received byte available on byte_data (one-cycle strobe) |
| byte_data | input | 8 | Received byte; [7:1] address bits, [0] direction |
| own_addr | input | OWN_W | Programmed target address (7-bit mode uses [6:0]) |
| addr_mask | input | OWN_W | 1 marks the address bit as don't-care |
| ten_bit_mode | input | 1 | 1 selects 10-bit addressing |
| gc_enable | input | 1 | Allows the general-call address to be acknowledged |
| mask_bypass | input | 1 | 1 forces exact compare and ignores the mask |
| byte_ack | output | 1 | Acknowledge the last address byte |
| addr_match | output | 1 | Complete own-address match reached |
| gen_call | output | 1 | Acknowledge came from the general-call address |
| read_dir | output | 1 | Matched transfer is a read |

## Verification
The bench sweeps every byte value against several own-address and mask settings.

- **Reserved filter and full mask.** A full mask and a reserved own address both stress the filter. A design that lets the mask override the filter would acknowledge reserved and header patterns in 7-bit mode.
- **General call.** General call is checked with the enable on and off. A design that reached 0x00 through the mask, or raised `addr_match` for it, would be caught there.
- **10-bit low byte.** The low byte is swept after an accepted header. A design that flagged the match on the header alone would show `addr_match` one byte too early.
- **Read restart.** The read restart is tried after a full match, after a STOP, and after a failed low byte. A design that remembered the match too long, or never, would misreport the read header.

// File: rtl/i2cam_pkg.sv
package i2cam_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_FIRST = 2'd1,
    PH_LOW   = 2'd2
  } phase_t;

  typedef struct packed {
    logic ack;
    logic match;
    logic gcall;
    logic rd;
    logic go_low;
    logic full10;
  } verdict_t;

  localparam logic [4:0] HDR10 = 5'b11110;

endpackage

// File: rtl/i2cam_mask_eq.sv
module i2cam_mask_eq #(
  parameter int W = 7
) (
  input  logic [W-1:0] rx,
  input  logic [W-1:0] ref_val,
  input  logic [W-1:0] dc,
  output logic         eq
);
  logic [W-1:0] bit_ok;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign bit_ok[i] = dc[i] | ~(rx[i] ^ ref_val[i]);
  end

  assign eq = &bit_ok;
endmodule

// File: rtl/i2cam_first_dec.sv
module i2cam_first_dec
  import i2cam_pkg::*;
#(
  parameter int OWN_W = 10
) (
  input  logic [7:0]       rx,
  input  logic [OWN_W-1:0] own,
  input  logic [OWN_W-1:0] dc,
  input  logic             ten_bit,
  input  logic             gc_en,
  input  logic             prior_full,
  output verdict_t         v
);
  localparam int SHORT_W = 7;
  localparam int HI_W    = OWN_W - 8;

  logic [SHORT_W-1:0] addr7;
  logic               rw;
  logic               is_gc;
  logic               reserved;
  logic               is_hdr;
  logic               eq7;
  logic               eq_hi;

  assign addr7    = rx[7:1];
  assign rw       = rx[0];
  assign is_gc    = (rx == 8'h00);
  assign reserved = (addr7[6:3] == 4'b0000) || (addr7[6:3] == 4'b1111);
  assign is_hdr   = (rx[7:3] == HDR10);

  i2cam_mask_eq #(.W(SHORT_W)) u_eq7 (
    .rx(addr7), .ref_val(own[SHORT_W-1:0]), .dc(dc[SHORT_W-1:0]), .eq(eq7)
  );

  i2cam_mask_eq #(.W(HI_W)) u_eq_hi (
    .rx(rx[HI_W:1]), .ref_val(own[OWN_W-1:8]), .dc(dc[OWN_W-1:8]), .eq(eq_hi)
  );

  always_comb begin
    v = '0;
    if (is_gc) begin
      v.ack   = gc_en;
      v.gcall = gc_en;
    end else if (!ten_bit) begin
      if (!reserved && eq7) begin
        v.ack   = 1'b1;
        v.match = 1'b1;
        v.rd    = rw;
      end
    end else if (is_hdr && eq_hi) begin
      if (!rw) begin
        v.ack    = 1'b1;
        v.go_low = 1'b1;
      end else if (prior_full) begin
        v.ack    = 1'b1;
        v.match  = 1'b1;
        v.rd     = 1'b1;
        v.full10 = 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
  import i2cam_pkg::*;
#(
  parameter int OWN_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_evt,
  input  logic             stop_evt,
  input  logic             byte_valid,
  input  logic [7:0]       byte_data,
  input  logic [OWN_W-1:0] own_addr,
  input  logic [OWN_W-1:0] addr_mask,
  input  logic             ten_bit_mode,
  input  logic             gc_enable,
  input  logic             mask_bypass,
  output logic             byte_ack,
  output logic             addr_match,
  output logic             gen_call,
  output logic             read_dir
);
  localparam int LOW_W = 8;

  logic [OWN_W-1:0] dc_eff;
  phase_t           phase;
  logic             full10;
  verdict_t         first_v;
  logic             low_eq;

  assign dc_eff = mask_bypass ? '0 : addr_mask;

  i2cam_first_dec #(.OWN_W(OWN_W)) u_first (
    .rx(byte_data), .own(own_addr), .dc(dc_eff), .ten_bit(ten_bit_mode),
    .gc_en(gc_enable), .prior_full(full10), .v(first_v)
  );

  i2cam_mask_eq #(.W(LOW_W)) u_low (
    .rx(byte_data), .ref_val(own_addr[LOW_W-1:0]), .dc(dc_eff[LOW_W-1:0]), .eq(low_eq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      full10     <= 1'b0;
      byte_ack   <= 1'b0;
      addr_match <= 1'b0;
      gen_call   <= 1'b0;
      read_dir   <= 1'b0;
    end else if (stop_evt) begin
      phase      <= PH_IDLE;
      full10     <= 1'b0;
      byte_ack   <= 1'b0;
      addr_match <= 1'b0;
      gen_call   <= 1'b0;
      read_dir   <= 1'b0;
    end else if (start_evt) begin
      phase      <= PH_FIRST;
      byte_ack   <= 1'b0;
      addr_match <= 1'b0;
      gen_call   <= 1'b0;
      read_dir   <= 1'b0;
    end else if (byte_valid) begin
      case (phase)
        PH_FIRST: begin
          byte_ack   <= first_v.ack;
          addr_match <= first_v.match;
          gen_call   <= first_v.gcall;
          read_dir   <= first_v.rd;
          phase      <= first_v.go_low ? PH_LOW : PH_IDLE;
          if (!first_v.go_low) full10 <= first_v.full10;
        end
        PH_LOW: begin
          byte_ack   <= low_eq;
          addr_match <= low_eq;
          gen_call   <= 1'b0;
          read_dir   <= 1'b0;
          full10     <= low_eq;
          phase      <= PH_IDLE;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_addr_match_chk.sv
module i2c_addr_match_chk (
  input logic clk,
  input logic rst_n,
  input logic start_evt,
  input logic stop_evt,
  input logic byte_valid,
  input logic gc_enable,
  input logic byte_ack,
  input logic addr_match,
  input logic gen_call,
  input logic read_dir
);
  // R9
  clear_on_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt || stop_evt) |=> (!byte_ack && !addr_match && !gen_call && !read_dir));

  // R5
  gcall_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gen_call |-> (byte_ack && !addr_match && !read_dir));

  // R5
  gcall_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gen_call) |-> $past(gc_enable));

  // R7
  match_acked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_match |-> byte_ack);

  // R8
  read_needs_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    read_dir |-> addr_match);

  // R10
  hold_when_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!byte_valid && !start_evt && !stop_evt) |=>
      ($stable(byte_ack) && $stable(addr_match) && $stable(gen_call) && $stable(read_dir)));
endmodule

bind i2c_addr_match i2c_addr_match_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .stop_evt(stop_evt),
  .byte_valid(byte_valid), .gc_enable(gc_enable), .byte_ack(byte_ack),
  .addr_match(addr_match), .gen_call(gen_call), .read_dir(read_dir)
);

// File: tb/i2c_addr_match_test.sv
module i2c_addr_match_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_evt = 1'b0;
  logic       stop_evt = 1'b0;
  logic       byte_valid = 1'b0;
  logic [7:0] byte_data = 8'h00;
  logic [9:0] own_addr = '0;
  logic [9:0] addr_mask = '0;
  logic       ten_bit_mode = 1'b0;
  logic       gc_enable = 1'b0;
  logic       mask_bypass = 1'b0;
  logic       byte_ack, addr_match, gen_call, read_dir;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  i2c_addr_match uut (
    .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .stop_evt(stop_evt),
    .byte_valid(byte_valid), .byte_data(byte_data), .own_addr(own_addr),
    .addr_mask(addr_mask), .ten_bit_mode(ten_bit_mode), .gc_enable(gc_enable),
    .mask_bypass(mask_bypass), .byte_ack(byte_ack), .addr_match(addr_match),
    .gen_call(gen_call), .read_dir(read_dir)
  );

  function automatic logic [3:0] outs();
    return {byte_ack, addr_match, gen_call, read_dir};
  endfunction

  // Expected {ack, match, gcall, rd} for a first address byte.
  function automatic logic [3:0] exp_first(input logic [7:0] b, input logic [9:0] own,
                                           input logic [9:0] m, input logic ten,
                                           input logic gce, input logic prior);
    int a7, top4;
    a7 = int'(b) / 2;
    top4 = a7 / 8;
    if (b == 8'h00) return {gce, 1'b0, gce, 1'b0};
    if (!ten) begin
      if (top4 == 0 || top4 == 15) return 4'b0000;
      if (((a7 ^ int'(own[6:0])) & ~int'(m[6:0]) & 8'h7F) == 0) return {3'b110, b[0]};
      return 4'b0000;
    end
    if ((int'(b) / 8) == 30 && (((int'(b[2:1]) ^ int'(own[9:8])) & ~int'(m[9:8]) & 3) == 0)) begin
      if (b[0] == 1'b0) return 4'b1000;
      if (prior) return 4'b1101;
    end
    return 4'b0000;
  endfunction

  task automatic chk(input string req, input logic [3:0] got, input logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got ack/match/gc/rd=%b expected %b", req, got, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start_evt = 1'b1;
    @(negedge clk); start_evt = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk); stop_evt = 1'b1;
    @(negedge clk); stop_evt = 1'b0;
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); byte_valid = 1'b1; byte_data = b;
    @(negedge clk); byte_valid = 1'b0;
  endtask

  task automatic sweep7(input logic [9:0] own, input logic [9:0] m,
                        input logic byp, input logic gce);
    logic [9:0] meff;
    own_addr = own; addr_mask = m; mask_bypass = byp; gc_enable = gce;
    ten_bit_mode = 1'b0;
    meff = byp ? 10'h000 : m;
    for (int b = 0; b < 256; b++) begin
      string req;
      pulse_start();
      send(8'(b));
      if (b == 0) req = "R5";
      else if ((b / 16) == 0 || (b / 16) == 15) req = "R4";
      else if (byp) req = "R3";
      else req = "R2";
      chk(req, outs(), exp_first(8'(b), own, meff, 1'b0, gce, 1'b0));
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [3:0] held;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", outs(), 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", outs(), 4'b0000);

    // R2 / R3 / R4 / R5: 7-bit sweeps
    sweep7(10'h05A, 10'h000, 1'b0, 1'b1);
    sweep7(10'h05A, 10'h021, 1'b0, 1'b0);
    sweep7(10'h012, 10'h07F, 1'b0, 1'b1);
    sweep7(10'h05A, 10'h021, 1'b1, 1'b1);
    sweep7(10'h003, 10'h000, 1'b0, 1'b0);

    // R10: data bytes after a match leave outputs alone
    own_addr = 10'h05A; addr_mask = '0; mask_bypass = 1'b0; gc_enable = 1'b0;
    pulse_start();
    send({7'h5A, 1'b1});
    chk("R2", outs(), 4'b1101);
    held = outs();
    send(8'h00);
    send(8'hFF);
    chk("R10", outs(), held);

    // R9: STOP and START clear outputs
    pulse_stop();
    chk("R9", outs(), 4'b0000);
    pulse_start();
    send({7'h5A, 1'b0});
    chk("R2", outs(), 4'b1100);
    pulse_start();
    chk("R9", outs(), 4'b0000);

    // R6: 10-bit header sweep without prior match
    ten_bit_mode = 1'b1; own_addr = 10'h2C5; gc_enable = 1'b1;
    for (int pass = 0; pass < 3; pass++) begin
      logic [9:0] meff;
      addr_mask   = (pass == 0) ? 10'h000 : 10'h30F;
      mask_bypass = (pass == 2);
      meff = mask_bypass ? 10'h000 : addr_mask;
      for (int b = 0; b < 256; b++) begin
        pulse_stop();
        pulse_start();
        send(8'(b));
        chk(b == 0 ? "R5" : (pass == 2 ? "R3" : "R6"), outs(),
            exp_first(8'(b), own_addr, meff, 1'b1, 1'b1, 1'b0));
      end
    end

    // R7: low-byte sweep after an accepted header
    for (int pass = 0; pass < 2; pass++) begin
      addr_mask = (pass == 0) ? 10'h000 : 10'h30F;
      mask_bypass = 1'b0;
      for (int l = 0; l < 256; l++) begin
        logic exp_hit;
        pulse_stop();
        pulse_start();
        send({5'b11110, own_addr[9:8], 1'b0});
        chk("R6", outs(), 4'b1000);
        send(8'(l));
        exp_hit = (((l ^ int'(own_addr[7:0])) & ~int'(addr_mask[7:0]) & 8'hFF) == 0);
        chk("R7", outs(), {exp_hit, exp_hit, 2'b00});
      end
    end

    // R8: read restart after a full match
    addr_mask = '0;
    pulse_stop();
    pulse_start();
    send({5'b11110, own_addr[9:8], 1'b0});
    send(own_addr[7:0]);
    chk("R7", outs(), 4'b1100);
    pulse_start();
    chk("R9", outs(), 4'b0000);
    send({5'b11110, own_addr[9:8], 1'b1});
    chk("R8", outs(), 4'b1101);
    pulse_start();
    send({5'b11110, own_addr[9:8], 1'b1});
    chk("R8", outs(), 4'b1101);
    // R9: STOP forgets the full match
    pulse_stop();
    pulse_start();
    send({5'b11110, own_addr[9:8], 1'b1});
    chk("R8", outs(), 4'b0000);
    // R8: failed low byte also forgets it
    pulse_start();
    send({5'b11110, own_addr[9:8], 1'b0});
    send(own_addr[7:0]);
    chk("R7", outs(), 4'b1100);
    pulse_start();
    send({5'b11110, own_addr[9:8], 1'b0});
    send(own_addr[7:0] ^ 8'h01);
    chk("R7", outs(), 4'b0000);
    pulse_start();
    send({5'b11110, own_addr[9:8], 1'b1});
    chk("R8", outs(), 4'b0000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule